// File: doc/BRIEF.md
# Per-Slave Bus Arbiter

This block sits in front of one slave port of a multi-layer interconnect and decides which of up to nine masters owns that slave. Each slave gets its own copy, so every slave may run its own strategy. Two strategies are available. In fixed priority, each master carries a 2-bit level and the highest level wins. In round robin, the search for the next owner starts just after the most recent owner.

Once granted, a master keeps the slave until it drops its request, signals the end of its burst, or uses up its slot. The slot is a programmable number of cycles counted while a burst is open. It caps bursts of undefined length so that other masters get a turn. When nobody requests, a default-master policy decides the idle grant. The options are nobody, the last master that was granted, or a configured master index. The early grant saves the default master one arbitration cycle on its next access. Address decoding and the data path belong to neighbouring blocks.

Top module: `slv_arbiter`

## Requirements
- R1: After reset, `gnt_o` is all zeros.
- R2: `gnt_o` has at most one bit set and changes only on a rising clock edge. When any request is present in a cycle, the grant after the next edge belongs to a master that requested in that cycle.
- R3: With `cfg_rr_i`=0, the winner is the requester with the largest 2-bit level, where master i's level is `cfg_prio_i[2i+1:2i]`. On equal levels, the lower master index wins.
- R4: With `cfg_rr_i`=1, the winner is the first requester found by searching upward from the index after the most recent owner, wrapping after index 8. After reset, the search starts at master 0.
- R5: The owner keeps the grant while it requests, `bst_end_i` is low and its slot has not expired.
- R6: `bst_end_i` high while the owner requests causes a fresh arbitration at the next edge, among all requesters.
- R7: When the owner stops requesting, the next edge re-arbitrates among the requesters.
- R8: On every fresh arbitration, the slot counter is loaded with `cfg_slot_i`. A burst is open from the cycle `bst_start_i` is high until the next arbitration. The owner keeps the grant for at most `cfg_slot_i` open-burst cycles. Then the slave passes to another requester, or goes back to the owner if it is the only requester.
- R9: `cfg_slot_i` = 0 disables slot expiry, and an open burst is never broken.
- R10: `cfg_dflt_i` = 0 (and the unused code 3) selects no default master: with no request, the next grant is all zeros.
- R11: `cfg_dflt_i` = 1 selects last-owner default: with no request, the grant is held unchanged.
- R12: `cfg_dflt_i` = 2 selects a fixed default: with no request, master `cfg_dflt_idx_i` is granted, or nobody if that index is 9 or above.
- R13: When slot expiry and `bst_end_i` fall in the same cycle, the expiry rule applies. The owner is excluded whenever another master requests, even under fixed priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 9 | Request per master |
| bst_start_i | input | 1 | The current owner opens a burst this cycle |
| bst_end_i | input | 1 | The current owner's burst ends this cycle |
| cfg_rr_i | input | 1 | 0 selects fixed priority, 1 selects round robin |
| cfg_prio_i | input | 18 | 2-bit level per master, master i at bits [2i+1:2i] |
| cfg_dflt_i | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed index, 3 none |
| cfg_dflt_idx_i | input | 4 | Master index used by the fixed idle policy |
| cfg_slot_i | input | 8 | Slot length in open-burst cycles, 0 disables breaking |
| gnt_o | output | 9 | One-hot grant |

## Verification
Burst end and slot expiry can fall in the same cycle. The two events call for different outcomes: a burst end alone lets a high-level owner win again, while expiry excludes it. A directed case sets fixed priority, a slot length of two and a higher-level owner against a lower-level rival, then raises `bst_end_i` in the very cycle the slot runs out. The expected grant goes to the rival. Random stimulus also produces such overlaps, and every cycle is compared with a bench model written from the requirements.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

  typedef enum logic [1:0] {
    DFLT_NONE  = 2'd0,
    DFLT_LAST  = 2'd1,
    DFLT_FIXED = 2'd2,
    DFLT_RSVD  = 2'd3
  } dflt_mode_e;

endpackage

// File: rtl/slv_arb_fixed_pick.sv
module slv_arb_fixed_pick #(
  parameter int N      = 9,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]        cand_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    win_o
);

  logic [PRIO_W-1:0] best_lvl;

  // strict comparison keeps the lower index on equal levels
  always_comb begin
    hit_o    = 1'b0;
    win_o    = '0;
    best_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!hit_o || (prio_i[i*PRIO_W +: PRIO_W] > best_lvl))) begin
        hit_o    = 1'b1;
        win_o    = IDX_W'(i);
        best_lvl = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/slv_arb_rr_pick.sv
module slv_arb_rr_pick #(
  parameter int N     = 9,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] win_o
);

  int pos;

  // search upward from last_i + 1, wrapping once around all masters
  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    pos   = 0;
    for (int k = 1; k <= N; k++) begin
      pos = int'(last_i) + k;
      if (pos >= N) pos = pos - N;
      if (!hit_o && (pos < N) && cand_i[pos]) begin
        hit_o = 1'b1;
        win_o = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/slv_arb_slot_ctr.sv
module slv_arb_slot_ctr #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              bst_start_i,
  output logic              expire_o
);

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              inb_q, inb_d;
  logic              counting;

  assign counting = inb_q | bst_start_i;
  assign expire_o = (slot_i != '0) && counting && (cnt_q == SLOT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    inb_d = inb_q;
    if (load_i) begin
      cnt_d = slot_i;
      inb_d = 1'b0;
    end else begin
      if (counting && (cnt_q != '0)) cnt_d = cnt_q - SLOT_W'(1);
      if (bst_start_i) inb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q <= '0;
      inb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      inb_q <= inb_d;
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_ns)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/slv_arbiter.sv
module slv_arbiter
  import slv_arb_pkg::*;
#(
  parameter int NUM_M  = 9,
  parameter int PRIO_W = 2,
  parameter int SLOT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        req_i,
  input  logic                    bst_start_i,
  input  logic                    bst_end_i,
  input  logic                    cfg_rr_i,
  input  logic [NUM_M*PRIO_W-1:0] cfg_prio_i,
  input  logic [1:0]              cfg_dflt_i,
  input  logic [$clog2(NUM_M)-1:0] cfg_dflt_idx_i,
  input  logic [SLOT_W-1:0]       cfg_slot_i,
  output logic [NUM_M-1:0]        gnt_o
);

  localparam int IDX_W = $clog2(NUM_M);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  logic [NUM_M-1:0] gnt_q, gnt_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             gnt_en;
  logic             owner_req, expire, brk, arb_en;
  logic [NUM_M-1:0] cand_others, cand;
  logic             fx_hit, rr_hit, hit;
  logic [IDX_W-1:0] fx_win, rr_win, win;
  dflt_mode_e       dflt_mode;

  assign dflt_mode = dflt_mode_e'(cfg_dflt_i);
  assign owner_req = |(gnt_q & req_i);
  assign arb_en    = !owner_req || bst_end_i || expire;
  assign brk       = owner_req && expire;
  assign cand_others = req_i & ~gnt_q;
  assign cand      = (brk && (cand_others != '0)) ? cand_others : req_i;

  slv_arb_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .load_i      (arb_en),
    .slot_i      (cfg_slot_i),
    .bst_start_i (bst_start_i),
    .expire_o    (expire)
  );

  slv_arb_fixed_pick #(.N(NUM_M), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_fx (
    .cand_i (cand),
    .prio_i (cfg_prio_i),
    .hit_o  (fx_hit),
    .win_o  (fx_win)
  );

  slv_arb_rr_pick #(.N(NUM_M), .IDX_W(IDX_W)) u_rr (
    .cand_i (cand),
    .last_i (last_q),
    .hit_o  (rr_hit),
    .win_o  (rr_win)
  );

  assign hit = cfg_rr_i ? rr_hit : fx_hit;
  assign win = cfg_rr_i ? rr_win : fx_win;

  always_comb begin
    gnt_en = arb_en;
    gnt_d  = gnt_q;
    last_d = last_q;
    if (hit) begin
      for (int i = 0; i < NUM_M; i++) gnt_d[i] = (win == IDX_W'(i));
      last_d = win;
    end else begin
      unique case (dflt_mode)
        DFLT_LAST:  gnt_d = gnt_q;
        DFLT_FIXED: for (int i = 0; i < NUM_M; i++) gnt_d[i] = (cfg_dflt_idx_i == IDX_W'(i));
        default:    gnt_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      gnt_q  <= '0;
      last_q <= IDX_W'(NUM_M - 1);
    end else if (gnt_en) begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(gnt_o)); // R2
  AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_i != '0) |=> ((gnt_o & $past(req_i)) != '0)); // R2
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    ((cfg_slot_i == '0) && ((gnt_o & req_i) != '0) && !bst_end_i) |=> $stable(gnt_o)); // R5
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_ns)
    ((req_i == '0) && (cfg_dflt_i == 2'd0)) |=> (gnt_o == '0)); // R10
  AST_IDLE_LAST: assert property (@(posedge clk) disable iff (!rst_ns)
    ((req_i == '0) && (cfg_dflt_i == 2'd1)) |=> $stable(gnt_o)); // R11

endmodule

// File: tb/sim_slv_arbiter.sv
`timescale 1ns/1ps
module sim_slv_arbiter;

  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         bs, be;
  logic         cfg_rr;
  logic [17:0]  cfg_prio;
  logic [1:0]   cfg_dflt;
  logic [3:0]   cfg_idx;
  logic [7:0]   cfg_slot;
  logic [N-1:0] gnt;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [N-1:0] m_gnt;
  int           m_last, m_cnt;
  bit           m_inb;

  always #5 clk = ~clk;

  slv_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bst_start_i(bs), .bst_end_i(be),
    .cfg_rr_i(cfg_rr), .cfg_prio_i(cfg_prio), .cfg_dflt_i(cfg_dflt),
    .cfg_dflt_idx_i(cfg_idx), .cfg_slot_i(cfg_slot), .gnt_o(gnt)
  );

  function automatic int lvl(int i);
    return int'(cfg_prio[2*i +: 2]);
  endfunction

  function automatic int pick_fixed(logic [N-1:0] c);
    int w = -1;
    for (int i = 0; i < N; i++)
      if (c[i] && (w < 0 || lvl(i) > lvl(w))) w = i;
    return w;
  endfunction

  function automatic int pick_rr(logic [N-1:0] c, int last);
    for (int k = 1; k <= N; k++) begin
      int p = (last + k) % N;
      if (c[p]) return p;
    end
    return -1;
  endfunction

  task automatic model_step();
    bit owner = |(m_gnt & req);
    bit open  = m_inb || bs;
    bit exp_s = (cfg_slot != 0) && open && (m_cnt == 1);
    if (owner && !be && !exp_s) begin
      if (open && m_cnt != 0) m_cnt = m_cnt - 1;
      if (bs) m_inb = 1;
    end else begin
      logic [N-1:0] c = req;
      int w;
      if (owner && exp_s && ((req & ~m_gnt) != 0)) c = req & ~m_gnt;
      if (c != 0) begin
        w = cfg_rr ? pick_rr(c, m_last) : pick_fixed(c);
        m_gnt = '0;
        m_gnt[w] = 1'b1;
        m_last = w;
      end else if (cfg_dflt == 2'd1) begin
        m_gnt = m_gnt;
      end else if (cfg_dflt == 2'd2) begin
        m_gnt = '0;
        if (cfg_idx < N) m_gnt[cfg_idx] = 1'b1;
      end else begin
        m_gnt = '0;
      end
      m_cnt = int'(cfg_slot);
      m_inb = 0;
    end
  endtask

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s gnt actual=%h expected=%h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // drive after a falling edge, then compare at the next falling edge
  task automatic step(string tag, logic [N-1:0] r, logic s, logic e);
    req = r; bs = s; be = e;
    model_step();
    @(negedge clk);
    chk(tag, gnt, m_gnt);
  endtask

  task automatic do_reset();
    req = '0; bs = 0; be = 0; cfg_dflt = 2'd0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_gnt = '0; m_last = N - 1; m_cnt = 0; m_inb = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cfg_rr = 0; cfg_prio = '0; cfg_idx = '0; cfg_slot = '0;
    do_reset();
    chk("R1 reset", gnt, '0);

    step("R10 idle none", '0, 0, 0);
    chk("R10 literal", gnt, '0);

    // fixed priority: m3=2, m5=3, m7=3
    cfg_prio = '0;
    cfg_prio[6 +: 2] = 2'd2; cfg_prio[10 +: 2] = 2'd3; cfg_prio[14 +: 2] = 2'd3;
    step("R3 level", 9'h0A8, 0, 0);
    chk("R3 level literal", gnt, 9'h020);
    step("R7 owner drop", 9'h088, 0, 0);
    chk("R7 literal", gnt, 9'h080);
    step("R10 idle", '0, 0, 0);
    cfg_prio = {9{2'd1}};
    step("R3 tie", 9'h044, 0, 0);
    chk("R3 tie literal", gnt, 9'h004);

    // round robin from a fresh reset
    do_reset();
    cfg_rr = 1;
    step("R4 rr start", 9'h012, 0, 0);
    chk("R4 literal", gnt, 9'h002);
    step("R6 burst end", 9'h012, 0, 1);
    chk("R6 literal", gnt, 9'h010);
    step("R4 wrap", 9'h012, 0, 1);
    chk("R4 wrap literal", gnt, 9'h002);
    for (int i = 0; i < 5; i++) step("R5 hold", 9'h012, 0, 0);
    chk("R5 literal", gnt, 9'h002);

    // slot breaking, length 3
    cfg_slot = 8'd3;
    step("R8 idle", '0, 0, 0);
    step("R8 grant", 9'h012, 0, 0);
    chk("R8 grant literal", gnt, 9'h010);
    step("R8 open", 9'h012, 1, 0);
    step("R8 count", 9'h012, 0, 0);
    chk("R8 before expiry", gnt, 9'h010);
    step("R8 expiry", 9'h012, 0, 0);
    chk("R8 expiry literal", gnt, 9'h002);
    step("R8 sole open", 9'h002, 1, 0);
    step("R8 sole", 9'h002, 0, 0);
    step("R8 sole expiry", 9'h002, 0, 0);
    chk("R8 sole literal", gnt, 9'h002);

    cfg_slot = 8'd0;
    step("R9 load", 9'h012, 0, 1);
    step("R9 open", 9'h012, 1, 0);
    for (int i = 0; i < 20; i++) step("R9 no break", 9'h012, 0, 0);
    chk("R9 literal", gnt, 9'h010);

    // coincidence of expiry and burst end under fixed priority
    cfg_rr = 0; cfg_prio = '0; cfg_prio[1:0] = 2'd3; cfg_slot = 8'd2;
    step("R13 idle", '0, 0, 0);
    step("R13 grant", 9'h005, 0, 0);
    chk("R13 grant literal", gnt, 9'h001);
    step("R13 open", 9'h005, 1, 0);
    step("R13 both", 9'h005, 0, 1);
    chk("R13 literal", gnt, 9'h004);

    cfg_dflt = 2'd1;
    for (int i = 0; i < 3; i++) step("R11 hold", '0, 0, 0);
    chk("R11 literal", gnt, 9'h004);
    cfg_dflt = 2'd2; cfg_idx = 4'd6;
    step("R12 fixed", '0, 0, 0);
    chk("R12 literal", gnt, 9'h040);
    cfg_idx = 4'd12;
    step("R12 out of range", '0, 0, 0);
    chk("R12 range literal", gnt, '0);

    // constrained random
    for (int blk = 0; blk < 30; blk++) begin
      cfg_rr   = 1'($urandom_range(0, 1));
      cfg_prio = 18'($urandom);
      cfg_dflt = 2'($urandom_range(0, 3));
      cfg_idx  = 4'($urandom_range(0, 10));
      cfg_slot = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 6));
      for (int c = 0; c < 100; c++) begin
        logic [N-1:0] r;
        r = ($urandom_range(0, 4) == 0) ? '0 : N'($urandom);
        if ($urandom_range(0, 2) != 0) r = r | m_gnt;
        step("R2 random", r, ($urandom_range(0, 5) == 0), ($urandom_range(0, 9) == 0));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule